// File: doc/BRIEF.md
# Debug Control and Status Register

This block holds the 32-bit control and status word that an external debugger uses to steer a processor hart while the hart is halted. The debugger reaches it through a simple write port that is qualified by a 12-bit register address; the full current value is always visible on a read output. A second, hardware-driven port records the state of the hart when it enters debug mode: the privilege level and virtualization bit it came from, why it halted, and an extended reason code.

Elaboration parameters decide which optional fields exist. These cover the virtualization-related bits, the supervisor-mode and user-mode ebreak enables, the critical-error trigger enable and the landing-pad-expected bit. Four configurable fields (step interrupt enable, stop counters, stop time, mprv enable) can each be fixed at 0, fixed at 1, or left writable. The block also sets the version code. A live non-maskable-interrupt pending input shows through in the register unregistered. Deciding when to enter debug mode is left to the surrounding core.

Top module: `dbg_ctl_csr`

## Requirements
- R1: After reset the register reads the version code in bits 31:28, privilege 3 in bits 1:0, 1 in each configurable field fixed at 1, and 0 everywhere else. With default parameters this is 0x40000403.
- R2: A write with `csrWe` high and `csrAddr` equal to `CSR_ADDR` (default 0x7B0) updates every writable bit on the next clock edge. The writable bits are step (2), ebreak-M (15), and, when present, critical-error trigger (19), landing-pad (18), ebreak-VS (17), ebreak-VU (16), ebreak-S (13), ebreak-U (12) and virtualization (5), plus any configurable field set writable: step interrupt (11), stop counters (10), stop time (9), mprv (4). A write with `csrWe` low or at another address changes nothing.
- R3: Debugger writes have no effect on the version (31:28), extended cause (26:24), cause (8:6) or NMI pending (3) fields, on unassigned bits 27, 23:20 and 14 (which read 0), or on configurable fields fixed at 0 or 1.
- R4: Bit 3 equals `nmiPending` in the same cycle.
- R5: With `entryValid` high, the next clock edge loads bits 1:0 with `entryPrv`, bit 5 with `entryVirt` (when virtualization exists), and bits 8:6 with `entryCause`. Bits 26:24 take `entryExtCause` when `entryCause` is 7 and 0 otherwise. Without `entryValid`, cause and extended cause hold.
- R6: When an entry capture and a debugger write fall in the same cycle, privilege, virtualization, cause and extended cause take the capture values, and all other writable bits take the write data.
- R7: A debugger write of privilege 2 stores 3. So does a write of 1 when supervisor mode is absent, or 0 when user mode is absent. Supported encodings are stored unchanged.
- R8: Absent optional fields read 0 whatever is written, and a configurable field fixed at 1 always reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| csrWe | input | 1 | Debugger write enable |
| csrAddr | input | 12 | Register address of the write |
| csrWdata | input | 32 | Debugger write data |
| entryValid | input | 1 | Debug-mode entry capture strobe |
| entryPrv | input | 2 | Privilege level at entry |
| entryVirt | input | 1 | Virtualization mode at entry |
| entryCause | input | 3 | Reason for entry |
| entryExtCause | input | 3 | Extended reason, kept only with reason 7 |
| nmiPending | input | 1 | Live NMI pending flag |
| csrValue | output | 32 | Current register value |

## Verification
Every cycle, the assertions check the following. The extended cause is nonzero only alongside cause 7. A capture always loads cause on the next edge and wins privilege over a concurrent write. A debugger write never stores privilege 2. The debugger-owned bits and the captured fields stay unchanged in cycles without their strobe. Exact bit values under each parameter set can only be seen in the bench's scenarios, which compare a default instance and a stripped-down instance against a behavioural model. These include the reset word, hardwired optional bits, legalization of unsupported privilege modes, and mixed write-plus-capture cycles.

// File: rtl/dbgcsr_pkg.sv
package dbgcsr_pkg;
  typedef enum logic [1:0] {FLD_RO0 = 2'd0, FLD_RO1 = 2'd1, FLD_RW = 2'd2} fld_mode_e;

  typedef struct packed {
    logic       wrEn;
    logic       capEn;
    logic [1:0] wrPrv;
  } csr_strobe_t;

  localparam logic [1:0] PRV_MACHINE = 2'd3;
  localparam logic [2:0] CAUSE_OTHER = 3'd7;

  // bit positions of the four configurable fields, index 0..3
  localparam logic [19:0] CFG_POS = {5'd4, 5'd9, 5'd10, 5'd11};

  function automatic logic [31:0] cfgMask(input logic [7:0] modes, input logic [1:0] want);
    logic [31:0] m;
    m = '0;
    for (int g = 0; g < 4; g++)
      if (modes[2*g +: 2] == want) m[CFG_POS[5*g +: 5]] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/dbg_csr_ctrl.sv
module dbg_csr_ctrl
  import dbgcsr_pkg::*;
#(
  parameter logic [11:0] CSR_ADDR = 12'h7B0,
  parameter bit HAS_SMODE = 1'b1,
  parameter bit HAS_UMODE = 1'b1
) (
  input  logic        csrWe,
  input  logic [11:0] csrAddr,
  input  logic [1:0]  wrPrvRaw,
  input  logic        entryValid,
  output csr_strobe_t strobe
);
  logic unsupported;

  always_comb begin
    unsupported = (wrPrvRaw == 2'd2)
               || (wrPrvRaw == 2'd1 && !HAS_SMODE)
               || (wrPrvRaw == 2'd0 && !HAS_UMODE);
    strobe.wrEn  = csrWe && (csrAddr == CSR_ADDR);
    strobe.capEn = entryValid;
    strobe.wrPrv = unsupported ? PRV_MACHINE : wrPrvRaw;
  end
endmodule

// File: rtl/dbg_csr_datapath.sv
module dbg_csr_datapath
  import dbgcsr_pkg::*;
#(
  parameter logic [3:0] DEBUG_VER     = 4'd4,
  parameter bit         HAS_VIRT      = 1'b1,
  parameter bit         HAS_SMODE     = 1'b1,
  parameter bit         HAS_UMODE     = 1'b1,
  parameter bit         HAS_CRITERR   = 1'b1,
  parameter bit         HAS_LANDPAD   = 1'b1,
  parameter fld_mode_e  STEPIE_MODE   = FLD_RW,
  parameter fld_mode_e  STOPCNT_MODE  = FLD_RO1,
  parameter fld_mode_e  STOPTIME_MODE = FLD_RO0,
  parameter fld_mode_e  MPRV_MODE     = FLD_RW
) (
  input  logic        clk,
  input  logic        rstN,
  input  csr_strobe_t strobe,
  input  logic [31:0] wdata,
  input  logic [1:0]  entryPrv,
  input  logic        entryVirt,
  input  logic [2:0]  entryCause,
  input  logic [2:0]  entryExtCause,
  input  logic        nmiPending,
  output logic [31:0] value
);
  localparam logic [7:0]  MODES = {MPRV_MODE, STOPTIME_MODE, STOPCNT_MODE, STEPIE_MODE};
  localparam logic [31:0] FIXED_RW = (32'h1 << 15) | (32'h1 << 2)
                                   | (HAS_CRITERR ? (32'h1 << 19) : 32'h0)
                                   | (HAS_LANDPAD ? (32'h1 << 18) : 32'h0)
                                   | (HAS_VIRT    ? (32'h3 << 16) : 32'h0)
                                   | (HAS_SMODE   ? (32'h1 << 13) : 32'h0)
                                   | (HAS_UMODE   ? (32'h1 << 12) : 32'h0);
  localparam logic [31:0] RW_MASK  = FIXED_RW | cfgMask(MODES, FLD_RW);
  localparam logic [31:0] ONE_MASK = cfgMask(MODES, FLD_RO1);

  logic [31:0] ctlQ;
  logic [1:0]  prvQ;
  logic [2:0]  causeQ, extQ;
  logic        vQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlQ   <= '0;
      prvQ   <= PRV_MACHINE;
      causeQ <= '0;
      extQ   <= '0;
    end else begin
      if (strobe.wrEn) ctlQ <= (ctlQ & ~RW_MASK) | (wdata & RW_MASK);
      if (strobe.capEn) begin
        prvQ   <= entryPrv;
        causeQ <= entryCause;
        extQ   <= (entryCause == CAUSE_OTHER) ? entryExtCause : 3'd0;
      end else if (strobe.wrEn) begin
        prvQ <= strobe.wrPrv;
      end
    end
  end

  generate
    if (HAS_VIRT) begin : g_virt
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)              vQ <= 1'b0;
        else if (strobe.capEn)  vQ <= entryVirt;
        else if (strobe.wrEn)   vQ <= wdata[5];
      end
    end else begin : g_novirt
      assign vQ = 1'b0;
    end
  endgenerate

  always_comb begin
    value        = (ctlQ & RW_MASK) | ONE_MASK;
    value[31:28] = DEBUG_VER;
    value[26:24] = extQ;
    value[8:6]   = causeQ;
    value[5]     = vQ;
    value[3]     = nmiPending;
    value[1:0]   = prvQ;
  end

  // R5: extended cause only accompanies the "other" cause
  assert_ext_only_other_R5: assert property (@(posedge clk) disable iff (!rstN)
    (extQ != 3'd0) |-> (causeQ == CAUSE_OTHER));
  // R5: capture loads cause on the next edge
  assert_cap_cause_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capEn |=> (causeQ == $past(entryCause)));
  // R6: capture beats a concurrent write on privilege
  assert_cap_wins_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capEn && strobe.wrEn) |=> (prvQ == $past(entryPrv)));
  // R7: debugger write never leaves the reserved privilege encoding
  assert_prv_legal_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && !strobe.capEn) |=> (prvQ != 2'd2));
  // R3: debugger-owned bits hold without a write
  assert_ctl_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrEn |=> $stable(ctlQ));
  // R3: captured fields hold without an entry
  assert_cause_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capEn |=> ($stable(causeQ) && $stable(extQ)));
endmodule

// File: rtl/dbg_ctl_csr.sv
module dbg_ctl_csr
  import dbgcsr_pkg::*;
#(
  parameter logic [11:0] CSR_ADDR      = 12'h7B0,
  parameter logic [3:0]  DEBUG_VER     = 4'd4,
  parameter bit          HAS_VIRT      = 1'b1,
  parameter bit          HAS_SMODE     = 1'b1,
  parameter bit          HAS_UMODE     = 1'b1,
  parameter bit          HAS_CRITERR   = 1'b1,
  parameter bit          HAS_LANDPAD   = 1'b1,
  parameter fld_mode_e   STEPIE_MODE   = FLD_RW,
  parameter fld_mode_e   STOPCNT_MODE  = FLD_RO1,
  parameter fld_mode_e   STOPTIME_MODE = FLD_RO0,
  parameter fld_mode_e   MPRV_MODE     = FLD_RW
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csrWe,
  input  logic [11:0] csrAddr,
  input  logic [31:0] csrWdata,
  input  logic        entryValid,
  input  logic [1:0]  entryPrv,
  input  logic        entryVirt,
  input  logic [2:0]  entryCause,
  input  logic [2:0]  entryExtCause,
  input  logic        nmiPending,
  output logic [31:0] csrValue
);
  csr_strobe_t strobe;

  dbg_csr_ctrl #(
    .CSR_ADDR(CSR_ADDR), .HAS_SMODE(HAS_SMODE), .HAS_UMODE(HAS_UMODE)
  ) u_ctrl (
    .csrWe(csrWe), .csrAddr(csrAddr), .wrPrvRaw(csrWdata[1:0]),
    .entryValid(entryValid), .strobe(strobe)
  );

  dbg_csr_datapath #(
    .DEBUG_VER(DEBUG_VER), .HAS_VIRT(HAS_VIRT), .HAS_SMODE(HAS_SMODE),
    .HAS_UMODE(HAS_UMODE), .HAS_CRITERR(HAS_CRITERR), .HAS_LANDPAD(HAS_LANDPAD),
    .STEPIE_MODE(STEPIE_MODE), .STOPCNT_MODE(STOPCNT_MODE),
    .STOPTIME_MODE(STOPTIME_MODE), .MPRV_MODE(MPRV_MODE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wdata(csrWdata),
    .entryPrv(entryPrv), .entryVirt(entryVirt), .entryCause(entryCause),
    .entryExtCause(entryExtCause), .nmiPending(nmiPending), .value(csrValue)
  );
endmodule

// File: tb/dbg_ctl_csr_tb.sv
`timescale 1ns/1ps
module dbg_ctl_csr_tb;
  import dbgcsr_pkg::*;

  typedef struct packed {
    logic [3:0] ver;
    logic virt, sm, um, crit, lp;
    logic [1:0] mStepie, mStopcnt, mStoptime, mMprv;
  } cfg_t;

  localparam cfg_t CFG0 = '{ver:4'd4,  virt:1'b1, sm:1'b1, um:1'b1, crit:1'b1, lp:1'b1,
                            mStepie:2'd2, mStopcnt:2'd1, mStoptime:2'd0, mMprv:2'd2};
  localparam cfg_t CFG1 = '{ver:4'd15, virt:1'b0, sm:1'b0, um:1'b1, crit:1'b0, lp:1'b0,
                            mStepie:2'd1, mStopcnt:2'd2, mStoptime:2'd2, mMprv:2'd0};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csrWe = 1'b0;
  logic [11:0] csrAddr = '0;
  logic [31:0] csrWdata = '0;
  logic entryValid = 1'b0;
  logic [1:0] entryPrv = '0;
  logic entryVirt = 1'b0;
  logic [2:0] entryCause = '0, entryExtCause = '0;
  logic nmiPending = 1'b0;
  logic [31:0] valA, valB;

  always #2 clk = ~clk;

  dbg_ctl_csr u_dut (
    .clk(clk), .rstN(rstN), .csrWe(csrWe), .csrAddr(csrAddr), .csrWdata(csrWdata),
    .entryValid(entryValid), .entryPrv(entryPrv), .entryVirt(entryVirt),
    .entryCause(entryCause), .entryExtCause(entryExtCause),
    .nmiPending(nmiPending), .csrValue(valA));

  dbg_ctl_csr #(
    .DEBUG_VER(4'd15), .HAS_VIRT(1'b0), .HAS_SMODE(1'b0), .HAS_UMODE(1'b1),
    .HAS_CRITERR(1'b0), .HAS_LANDPAD(1'b0), .STEPIE_MODE(FLD_RO1),
    .STOPCNT_MODE(FLD_RW), .STOPTIME_MODE(FLD_RW), .MPRV_MODE(FLD_RO0)
  ) u_dutBare (
    .clk(clk), .rstN(rstN), .csrWe(csrWe), .csrAddr(csrAddr), .csrWdata(csrWdata),
    .entryValid(entryValid), .entryPrv(entryPrv), .entryVirt(entryVirt),
    .entryCause(entryCause), .entryExtCause(entryExtCause),
    .nmiPending(nmiPending), .csrValue(valB));

  // behavioural reference model, one slot per instance
  logic [31:0] mBits [2];
  logic [1:0]  mPrv [2];
  logic [2:0]  mCause [2], mExt [2];
  int compared = 0, mismatched = 0, cyc = 0;
  bit running = 0, done = 0;
  string tag = "R1";

  function automatic cfg_t cfgOf(int i);
    return (i == 0) ? CFG0 : CFG1;
  endfunction

  function automatic bit canWrite(cfg_t c, int b);
    case (b)
      19: return c.crit;
      18: return c.lp;
      17, 16, 5: return c.virt;
      15, 2: return 1'b1;
      13: return c.sm;
      12: return c.um;
      11: return c.mStepie == 2'd2;
      10: return c.mStopcnt == 2'd2;
      9:  return c.mStoptime == 2'd2;
      4:  return c.mMprv == 2'd2;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit fixedOne(cfg_t c, int b);
    case (b)
      11: return c.mStepie == 2'd1;
      10: return c.mStopcnt == 2'd1;
      9:  return c.mStoptime == 2'd1;
      4:  return c.mMprv == 2'd1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [1:0] legalPrv(cfg_t c, logic [1:0] p);
    if (p == 2'd2) return 2'd3;
    if (p == 2'd1 && !c.sm) return 2'd3;
    if (p == 2'd0 && !c.um) return 2'd3;
    return p;
  endfunction

  function automatic logic [31:0] expVal(int i);
    cfg_t c;
    logic [31:0] v;
    c = cfgOf(i);
    v = '0;
    for (int b = 0; b < 32; b++)
      v[b] = canWrite(c, b) ? mBits[i][b] : fixedOne(c, b);
    v[31:28] = c.ver;
    v[26:24] = mExt[i];
    v[8:6]   = mCause[i];
    v[3]     = nmiPending;
    v[1:0]   = mPrv[i];
    return v;
  endfunction

  always @(posedge clk or negedge rstN) begin
    for (int i = 0; i < 2; i++) begin
      if (!rstN) begin
        mBits[i] = '0; mPrv[i] = 2'd3; mCause[i] = '0; mExt[i] = '0;
      end else begin
        if (csrWe && csrAddr == 12'h7B0) begin
          for (int b = 0; b < 32; b++)
            if (canWrite(cfgOf(i), b)) mBits[i][b] = csrWdata[b];
          mPrv[i] = legalPrv(cfgOf(i), csrWdata[1:0]);
        end
        if (entryValid) begin
          mPrv[i] = entryPrv;
          mBits[i][5] = cfgOf(i).virt ? entryVirt : 1'b0;
          mCause[i] = entryCause;
          mExt[i] = (entryCause == 3'd7) ? entryExtCause : 3'd0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (running && !done) begin
      for (int i = 0; i < 2; i++) begin
        logic [31:0] act, ex;
        act = (i == 0) ? valA : valB;
        ex  = expVal(i);
        compared++;
        if (act !== ex) begin
          mismatched++;
          $display("FAIL %s dut%0d: actual %h expected %h", tag, i, act, ex);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic step(input logic we, input logic [11:0] a, input logic [31:0] d,
                      input logic ev, input logic [1:0] ep, input logic vv,
                      input logic [2:0] ec, input logic [2:0] ee, input logic nm);
    @(posedge clk); #1;
    csrWe = we; csrAddr = a; csrWdata = d; entryValid = ev; entryPrv = ep;
    entryVirt = vv; entryCause = ec; entryExtCause = ee; nmiPending = nm;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(0, 12'h7B0, 32'h0, 0, 2'd0, 0, 3'd0, 3'd0, nmiPending);
  endtask

  initial begin
    mBits[0] = '0; mBits[1] = '0; mPrv[0] = 2'd3; mPrv[1] = 2'd3;
    mCause[0] = '0; mCause[1] = '0; mExt[0] = '0; mExt[1] = '0;
    @(posedge clk); running = 1;
    tag = "R1";
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
    idle(3);
    // R2: write all ones, then mixed patterns
    tag = "R2";
    step(1, 12'h7B0, 32'hFFFF_FFFF, 0, 2'd0, 0, 3'd0, 3'd0, 0); idle(1);
    step(1, 12'h7B0, 32'h0005_A5A5, 0, 2'd0, 0, 3'd0, 3'd0, 0); idle(1);
    step(1, 12'h7B0, 32'h1234_5678, 0, 2'd0, 0, 3'd0, 3'd0, 0); idle(1);
    // R2: wrong address and low enable are ignored
    step(1, 12'h7B1, 32'h0, 0, 2'd0, 0, 3'd0, 3'd0, 0); idle(1);
    step(0, 12'h7B0, 32'h0, 0, 2'd0, 0, 3'd0, 3'd0, 0); idle(1);
    // R3: clearing write leaves read-only fields
    tag = "R3";
    step(1, 12'h7B0, 32'h0000_0000, 0, 2'd0, 0, 3'd0, 3'd0, 0); idle(1);
    step(1, 12'h7B0, 32'hFFFF_FFFB, 0, 2'd0, 0, 3'd0, 3'd0, 0); idle(1);
    // R8: hardwired optional fields in the bare instance
    tag = "R8";
    step(1, 12'h7B0, 32'hFFFF_FFFF, 0, 2'd0, 0, 3'd0, 3'd0, 0); idle(2);
    // R4: nmi passes through
    tag = "R4";
    step(0, 12'h000, 32'h0, 0, 2'd0, 0, 3'd0, 3'd0, 1); idle(2);
    step(0, 12'h000, 32'h0, 0, 2'd0, 0, 3'd0, 3'd0, 0); idle(1);
    // R5: entry captures
    tag = "R5";
    step(0, 12'h0, 32'h0, 1, 2'd1, 1, 3'd3, 3'd5, 0); idle(1);
    step(0, 12'h0, 32'h0, 1, 2'd0, 0, 3'd7, 3'd2, 0); idle(1);
    step(0, 12'h0, 32'h0, 1, 2'd3, 1, 3'd4, 3'd6, 0); idle(1);
    // R6: capture and write together
    tag = "R6";
    step(1, 12'h7B0, 32'hFFFF_FFFE, 1, 2'd0, 0, 3'd2, 3'd1, 0); idle(1);
    step(1, 12'h7B0, 32'h0000_0021, 1, 2'd3, 1, 3'd7, 3'd4, 0); idle(1);
    // R7: privilege legalization
    tag = "R7";
    step(1, 12'h7B0, 32'h2, 0, 2'd0, 0, 3'd0, 3'd0, 0); idle(1);
    step(1, 12'h7B0, 32'h1, 0, 2'd0, 0, 3'd0, 3'd0, 0); idle(1);
    step(1, 12'h7B0, 32'h0, 0, 2'd0, 0, 3'd0, 3'd0, 0); idle(1);
    step(1, 12'h7B0, 32'h3, 0, 2'd0, 0, 3'd0, 3'd0, 0); idle(1);
    // R6: random mix of writes, captures and nmi
    tag = "R6";
    for (int k = 0; k < 400; k++) begin
      logic [1:0] p;
      p = 2'($urandom_range(0, 2));
      if (p == 2'd2) p = 2'd3;
      step(1'($urandom_range(0, 1)), ($urandom_range(0, 3) == 0) ? 12'h7B2 : 12'h7B0,
           $urandom, 1'($urandom_range(0, 1)), p, 1'($urandom_range(0, 1)),
           3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)));
    end
    idle(3);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule